// File: doc/BRIEF.md
# Cell-Granular ATM Buffer with Sticky Status

This block stores fixed-length ATM cells of 53 bytes. A byte-wide write side hands them in, and a read side drains them. The write side flags the first byte of every cell with a start-of-cell strobe. The storage holds four whole cells, one cell per slot. The read side takes bytes while its active-low enable is low and can hold off at any byte. The stream carries on from the held byte once the enable drops again.

Occupancy is counted in whole cells. The count rises only when a cell's 53rd byte has been stored. A space-available flag is taken from this count, so the flag can still show room while the last free slot is being filled. A cell whose start was accepted is always completed.

Three sticky status bits record events:
- the buffer becoming full;
- a cell refused because no slot was free;
- a framing error.

A small control port clears status bits by writing zeros and loads a per-bit interrupt enable mask. The interrupt output is the OR of the status bits masked by their enables.

Top module: `atmq_cell_fifo`

## Requirements
- R1: A cell is 53 bytes with `wr_soc` high on byte 0 only. Stored cells are replayed in arrival order with their bytes in order, and `rd_soc` is high exactly while byte 0 of a cell is presented.
- R2: `fill_cells` rises by one in the cycle after the clock edge that stores a cell's 53rd byte. It does not change while bytes 0..51 are being written.
- R3: `cell_avail` is 1 whenever `fill_cells` < 4. This includes the time while a fourth cell is being written. A cell whose start arrives with `fill_cells` = 3 is stored in full.
- R4: The buffer holds 4 cells. A start-of-cell byte that arrives with `fill_cells` = 4 is refused and all 53 bytes of that cell are discarded. The refusal sets overflow bit `stat_o[1]`.
- R5: Full bit `stat_o[0]` is set in the same cycle that `fill_cells` becomes 4.
- R6: Status bits are sticky. A control write with `csr_sel` = 0 clears each status bit whose `csr_wdata` bit is 0 and keeps each bit whose `csr_wdata` bit is 1. A status event in the same cycle as a clear leaves its bit set.
- R7: While `rd_enb_n` = 1, the presented byte (`rd_data`, `rd_soc`) is held. Output resumes with that same byte once `rd_enb_n` = 0.
- R8: A non-start byte that arrives outside a cell is dropped. A start strobe that arrives while a cell is being stored drops the partial cell and begins a new cell. Both cases set framing bit `stat_o[2]` and leave `fill_cells` unchanged.
- R9: A control write with `csr_sel` = 1 loads `irq_en_o` from `csr_wdata`. `irq` = OR over i of (`stat_o[i]` AND `irq_en_o[i]`).
- R10: After reset:
  - `fill_cells` = 0, `rd_valid` = 0 and `cell_avail` = 1;
  - `stat_o` = 0, `irq_en_o` = 0 and `irq` = 0.
- R11: If a cell's last byte is written in the same cycle that the last byte of another cell is read, `fill_cells` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte present |
| wr_soc | input | 1 | Write byte is byte 0 of a cell |
| wr_data | input | 8 | Write byte |
| cell_avail | output | 1 | Room for at least one more committed cell |
| rd_enb_n | input | 1 | Active-low read enable; the byte moves on a clock edge while it is low |
| rd_valid | output | 1 | A complete cell is available to read |
| rd_soc | output | 1 | Presented byte is byte 0 of a cell |
| rd_data | output | 8 | Presented read byte |
| fill_cells | output | 3 | Committed cells held |
| csr_wr | input | 1 | Control write strobe |
| csr_sel | input | 1 | 0: clear status bits, 1: load enable mask |
| csr_wdata | input | 3 | Control write data |
| stat_o | output | 3 | Sticky status: [0] full, [1] overflow, [2] framing |
| irq_en_o | output | 3 | Interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
Two functions of the block can act in the same cycle: the commit of a written cell, which raises the count, and the completion of a read cell, which lowers it. The bench arranges this overlap directly. It writes one cell completely and a second cell up to byte 51, then reads the first cell up to byte 51. In a single cycle it then drives the final write byte together with the final read transfer. The count must be unchanged after that edge, and the second cell must then read back intact. A second overlap is also provoked: a framing event and a status-clear write in the same cycle, where the set must win.

// File: rtl/atmq_pkg.sv
package atmq_pkg;
   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_FILL = 2'd1,
      WR_SKIP = 2'd2
   } wr_st_e;

   localparam int ST_FULL = 0;
   localparam int ST_OVF  = 1;
   localparam int ST_FRM  = 2;
   localparam int NSTAT   = 3;
endpackage

// File: rtl/atmq_wr_frame.sv
module atmq_wr_frame
   import atmq_pkg::*;
#(
   parameter int CELL_BYTES = 53,
   parameter int IDX_W      = 6,
   parameter int SLOT_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              wr_soc,
   input  logic              space_ok,
   output logic              mem_we,
   output logic [IDX_W-1:0]  mem_idx,
   output logic [SLOT_W-1:0] mem_slot,
   output logic              commit,
   output logic              ev_refuse,
   output logic              ev_frame
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

   wr_st_e             st_q, st_d;
   logic [IDX_W-1:0]   idx_q, idx_d;
   logic [SLOT_W-1:0]  slot_q;

   always_comb begin
      st_d      = st_q;
      idx_d     = idx_q;
      mem_we    = 1'b0;
      mem_idx   = idx_q;
      commit    = 1'b0;
      ev_refuse = 1'b0;
      ev_frame  = 1'b0;
      if (wr_valid) begin
         if (wr_soc) begin
            // a start strobe inside a stored cell abandons that cell
            ev_frame = (st_q == WR_FILL);
            idx_d    = IDX_W'(1);
            if (space_ok) begin
               mem_we  = 1'b1;
               mem_idx = '0;
               st_d    = WR_FILL;
            end else begin
               ev_refuse = 1'b1;
               st_d      = WR_SKIP;
            end
         end else begin
            case (st_q)
               WR_IDLE: ev_frame = 1'b1;
               WR_FILL: begin
                  mem_we = 1'b1;
                  if (idx_q == LAST) begin
                     commit = 1'b1;
                     st_d   = WR_IDLE;
                     idx_d  = '0;
                  end else begin
                     idx_d = idx_q + 1'b1;
                  end
               end
               WR_SKIP: begin
                  if (idx_q == LAST) begin
                     st_d  = WR_IDLE;
                     idx_d = '0;
                  end else begin
                     idx_d = idx_q + 1'b1;
                  end
               end
               default: st_d = WR_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WR_IDLE;
         idx_q  <= '0;
         slot_q <= '0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         if (commit) slot_q <= slot_q + 1'b1;
      end
   end

   assign mem_slot = slot_q;

   p_refuse_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_refuse |=> (st_q == WR_SKIP));
endmodule

// File: rtl/atmq_rd_seq.sv
module atmq_rd_seq #(
   parameter int CELL_BYTES = 53,
   parameter int IDX_W      = 6,
   parameter int SLOT_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              have_cell,
   input  logic              rd_enb_n,
   output logic              rd_valid,
   output logic              rd_soc,
   output logic              rd_done,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [SLOT_W-1:0] rd_slot
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

   logic xfer;

   assign rd_valid = have_cell;
   assign xfer     = have_cell && !rd_enb_n;
   assign rd_done  = xfer && (rd_idx == LAST);
   assign rd_soc   = have_cell && (rd_idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx  <= '0;
         rd_slot <= '0;
      end else if (xfer) begin
         if (rd_idx == LAST) begin
            rd_idx  <= '0;
            rd_slot <= rd_slot + 1'b1;
         end else begin
            rd_idx <= rd_idx + 1'b1;
         end
      end
   end

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (have_cell && rd_enb_n) |=> ($stable(rd_idx) && $stable(rd_slot)));
endmodule

// File: rtl/atmq_status.sv
module atmq_status #(
   parameter int NBITS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] ev,
   input  logic             csr_wr,
   input  logic             csr_sel,
   input  logic [NBITS-1:0] csr_wdata,
   output logic [NBITS-1:0] stat,
   output logic [NBITS-1:0] en,
   output logic             irq
);
   logic clr_wr;
   assign clr_wr = csr_wr && !csr_sel;

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= ev[i] | (bit_q & ~(clr_wr & ~csr_wdata[i]));
      end
      assign stat[i] = bit_q;

      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_q && !(clr_wr && !csr_wdata[i])) |=> stat[i]);
      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> stat[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 en <= '0;
      else if (csr_wr && csr_sel) en <= csr_wdata;
   end

   assign irq = |(stat & en);
endmodule

// File: rtl/atmq_cell_fifo.sv
module atmq_cell_fifo
   import atmq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CELL_BYTES  = 53,
   parameter int DEPTH_CELLS = 4,
   localparam int CNT_W      = $clog2(DEPTH_CELLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              wr_soc,
   input  logic [DATA_W-1:0] wr_data,
   output logic              cell_avail,
   input  logic              rd_enb_n,
   output logic              rd_valid,
   output logic              rd_soc,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fill_cells,
   input  logic              csr_wr,
   input  logic              csr_sel,
   input  logic [NSTAT-1:0]  csr_wdata,
   output logic [NSTAT-1:0]  stat_o,
   output logic [NSTAT-1:0]  irq_en_o,
   output logic              irq
);
   localparam int IDX_W   = $clog2(CELL_BYTES);
   localparam int SLOT_W  = $clog2(DEPTH_CELLS);
   localparam int BYTES   = DEPTH_CELLS * CELL_BYTES;
   localparam int ADDR_W  = $clog2(BYTES);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH_CELLS);

   initial begin
      a_depth_pow2: assert (DEPTH_CELLS >= 2 && (DEPTH_CELLS & (DEPTH_CELLS - 1)) == 0)
         else $error("DEPTH_CELLS must be a power of two of at least 2");
      a_cell_len: assert (CELL_BYTES >= 2)
         else $error("CELL_BYTES must be at least 2");
      a_data_w: assert (DATA_W >= 1)
         else $error("DATA_W must be positive");
   end

   logic              mem_we, commit, ev_refuse, ev_frame, rd_done, ev_full;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [SLOT_W-1:0] wr_slot, rd_slot;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] mem [BYTES];
   logic [NSTAT-1:0]  ev;

   assign cell_avail = (fill_cells < FULL_CNT);

   atmq_wr_frame #(.CELL_BYTES(CELL_BYTES), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) i_wr (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_soc(wr_soc),
      .space_ok(cell_avail), .mem_we(mem_we), .mem_idx(wr_idx), .mem_slot(wr_slot),
      .commit(commit), .ev_refuse(ev_refuse), .ev_frame(ev_frame)
   );

   atmq_rd_seq #(.CELL_BYTES(CELL_BYTES), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) i_rd (
      .clk(clk), .rst_n(rst_n), .have_cell(fill_cells != '0), .rd_enb_n(rd_enb_n),
      .rd_valid(rd_valid), .rd_soc(rd_soc), .rd_done(rd_done),
      .rd_idx(rd_idx), .rd_slot(rd_slot)
   );

   assign wr_addr = ADDR_W'(wr_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(wr_idx);
   assign rd_addr = ADDR_W'(rd_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);

   always_ff @(posedge clk) begin
      if (mem_we) mem[wr_addr] <= wr_data;
   end
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fill_cells <= '0;
      else        fill_cells <= fill_cells + CNT_W'(commit) - CNT_W'(rd_done);
   end

   assign ev_full      = commit && !rd_done && (fill_cells == FULL_CNT - 1'b1);
   assign ev[ST_FULL]  = ev_full;
   assign ev[ST_OVF]   = ev_refuse;
   assign ev[ST_FRM]   = ev_frame;

   atmq_status #(.NBITS(NSTAT)) i_st (
      .clk(clk), .rst_n(rst_n), .ev(ev), .csr_wr(csr_wr), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .stat(stat_o), .en(irq_en_o), .irq(irq)
   );

   p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cells <= FULL_CNT);
   p_refuse_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_refuse |-> (fill_cells == FULL_CNT));
   p_commit_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !rd_done) |=> (fill_cells == $past(fill_cells) + 1'b1));
   p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && rd_done) |=> $stable(fill_cells));
   p_full_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_cells != FULL_CNT) ##1 (fill_cells == FULL_CNT) |-> stat_o[ST_FULL]);
endmodule

// File: tb/test_atmq_cell_fifo.sv
module test_atmq_cell_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int NCELL = 53;
   // {stall, seed}
   localparam logic [8:0] VEC [0:3] = '{9'h011, 9'h1A0, 9'h0F3, 9'h155};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0, wr_soc = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_enb_n = 1'b1;
   logic       csr_wr = 1'b0, csr_sel = 1'b0;
   logic [2:0] csr_wdata = '0;
   logic       cell_avail, rd_valid, rd_soc, irq;
   logic [7:0] rd_data;
   logic [2:0] fill_cells, stat_o, irq_en_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   atmq_cell_fifo i_atmq_cell_fifo (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_soc(wr_soc), .wr_data(wr_data),
      .cell_avail(cell_avail), .rd_enb_n(rd_enb_n), .rd_valid(rd_valid), .rd_soc(rd_soc),
      .rd_data(rd_data), .fill_cells(fill_cells), .csr_wr(csr_wr), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .stat_o(stat_o), .irq_en_o(irq_en_o), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic write_part(input logic [7:0] seed, input int start, input int n);
      for (int i = start; i < start + n; i++) begin
         wr_valid = 1'b1;
         wr_soc   = (i == 0);
         wr_data  = seed + 8'(i);
         step();
      end
      wr_valid = 1'b0;
      wr_soc   = 1'b0;
   endtask

   task automatic read_part(input string req, input logic [7:0] seed, input int start,
                            input int n, input bit stall);
      int i = start;
      int cyc = 0;
      logic [31:0] bad_act = '0, bad_exp = '0;
      bit bad = 1'b0;
      while (i < start + n) begin
         bit en;
         en = !(stall && (cyc % 3 == 1));
         rd_enb_n = !en;
         if (!bad && !(rd_valid === 1'b1 && rd_data === seed + 8'(i) && rd_soc === (i == 0))) begin
            bad     = 1'b1;
            bad_act = {14'd0, rd_valid, rd_soc, 8'd0, rd_data};
            bad_exp = {14'd0, 1'b1, 1'(i == 0), 8'd0, seed + 8'(i)};
         end
         step();
         if (en) i++;
         cyc++;
      end
      rd_enb_n = 1'b1;
      chk(req, bad ? bad_act : 32'd0, bad ? bad_exp : 32'd0);
   endtask

   task automatic csr(input logic sel, input logic [2:0] d);
      csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
      step();
      csr_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R10 reset state
      chk("R10 fill", fill_cells, 0);
      chk("R10 rd_valid", rd_valid, 0);
      chk("R10 cell_avail", cell_avail, 1);
      chk("R10 stat", stat_o, 0);
      chk("R10 irq_en", irq_en_o, 0);
      chk("R10 irq", irq, 0);

      // vector table: write one cell, read it back with or without stalls
      for (int v = 0; v < 4; v++) begin
         write_part(VEC[v][7:0], 0, NCELL - 1);
         chk("R2 no count before last byte", fill_cells, 0);
         write_part(VEC[v][7:0], NCELL - 1, 1);
         chk("R2 count after last byte", fill_cells, 1);
         read_part("R1 R7 replay", VEC[v][7:0], 0, NCELL, VEC[v][8]);
         chk("R1 drained", fill_cells, 0);
      end

      // fill to four, optimistic flag, refusal
      for (int c = 0; c < 3; c++) write_part(8'h10 * 8'(c + 1), 0, NCELL);
      chk("R3 three held", fill_cells, 3);
      write_part(8'h50, 0, 30);
      chk("R3 avail while last slot fills", cell_avail, 1);
      write_part(8'h50, 30, NCELL - 30);
      chk("R3 fourth cell stored", fill_cells, 4);
      chk("R3 avail low when full", cell_avail, 0);
      chk("R5 full bit", stat_o[0], 1);
      chk("R4 no overflow yet", stat_o[1], 0);
      write_part(8'h77, 0, NCELL);
      chk("R4 refused keeps fill", fill_cells, 4);
      chk("R4 overflow bit", stat_o[1], 1);
      for (int c = 0; c < 3; c++) read_part("R4 order kept", 8'h10 * 8'(c + 1), 0, NCELL, 1'b0);
      read_part("R4 fourth cell", 8'h50, 0, NCELL, 1'b1);
      chk("R4 refused cell absent", rd_valid, 0);

      // R6 sticky clear
      chk("R6 before clear", stat_o, 3'b011);
      csr(1'b0, 3'b110);
      chk("R6 selective clear", stat_o, 3'b010);
      // stray byte (framing event) in the same cycle as a full clear
      wr_valid = 1'b1; wr_soc = 1'b0; wr_data = 8'hEE;
      csr_wr = 1'b1; csr_sel = 1'b0; csr_wdata = 3'b000;
      step();
      wr_valid = 1'b0; csr_wr = 1'b0;
      chk("R6 set wins over clear", stat_o, 3'b100);
      chk("R8 stray byte leaves fill", fill_cells, 0);

      // R9 interrupt
      csr(1'b1, 3'b100);
      chk("R9 enable readback", irq_en_o, 3'b100);
      chk("R9 irq asserted", irq, 1);
      csr(1'b1, 3'b011);
      chk("R9 irq masked", irq, 0);
      csr(1'b0, 3'b000);
      chk("R6 all cleared", stat_o, 0);

      // R8 mid-cell start strobe
      write_part(8'h20, 0, 10);
      write_part(8'h90, 0, NCELL);
      chk("R8 restart counted once", fill_cells, 1);
      chk("R8 framing bit", stat_o[2], 1);
      read_part("R8 restarted cell intact", 8'h90, 0, NCELL, 1'b0);
      csr(1'b0, 3'b000);

      // R11 commit and read-complete in one cycle
      write_part(8'h40, 0, NCELL);
      write_part(8'hC0, 0, NCELL - 1);
      read_part("R11 first part", 8'h40, 0, NCELL - 1, 1'b0);
      chk("R11 fill before", fill_cells, 1);
      chk("R11 last read byte", rd_data, 8'h40 + 8'(NCELL - 1));
      wr_valid = 1'b1; wr_soc = 1'b0; wr_data = 8'hC0 + 8'(NCELL - 1);
      rd_enb_n = 1'b0;
      step();
      wr_valid = 1'b0; rd_enb_n = 1'b1;
      chk("R11 fill unchanged", fill_cells, 1);
      read_part("R11 second cell", 8'hC0, 0, NCELL, 1'b1);
      chk("R11 drained", fill_cells, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule